// File: doc/BRIEF.md
# Word Load/Store and Integer Execute Unit

This block takes one 32-bit instruction word at a time, decodes it against five supported encodings (word load with zero fill, word store, word store that updates its base register, add of a signed immediate, and register OR) and executes it against an internal file of 32 general registers, each 64 bits wide. Effective addresses are formed by adding a sign-extended 16-bit displacement to a base value. The block drives a word-wide memory port and writes results back into its register file.

An instruction is accepted in any cycle where `instrValid` is high and `busy` is low. Stores, adds and ORs complete in the accepting cycle. A load raises `memRe` in the accepting cycle and takes the read data one cycle later; `busy` is high during that second cycle and no new instruction is taken. Encodings that match none of the five raise `illegal` and change nothing.

Top module: `word_exec_unit`

## Requirements
- R1: After reset every register holds zero, and with no instruction presented `busy`, `illegal`, `memWe` and `memRe` are low.
- R2: Add immediate (word bits 31:26 = 001110, target in bits 25:21, base field in bits 20:16, immediate in bits 15:0) writes base + immediate into the target; a base field of 0 means a base value of zero, not register 0.
- R3: The 16-bit displacement or immediate is sign-extended to 64 bits before the addition, so values 0x8000..0xFFFF subtract.
- R4: Load word (bits 31:26 = 100000, target in bits 25:21, base in 20:16, displacement in 15:0) drives `memRe` and the effective address in the accepting cycle, holds `busy` high for exactly the next cycle, and then writes the target with the upper 32 bits cleared and `memRdata` in the low 32 bits. A base field of 0 means a base of zero.
- R5: Store word (bits 31:26 = 100100, source in bits 25:21, base in 20:16, displacement in 15:0) drives `memWe`, the effective address, and the low 32 bits of the source on `memWdata` in the accepting cycle, without `memRe` and without writing any register. A base field of 0 means a base of zero.
- R6: Store word with update (bits 31:26 = 100101, same fields as R5) always reads the base register, register 0 included, performs the store and writes the effective address back into the base register.
- R7: Register OR (bits 31:26 = 011111, bits 10:1 = 0110111100, source S in 25:21, destination in 20:16, source B in 15:11, record flag in bit 0) writes S | B into the destination; the record flag does not change the result.
- R8: Any other instruction word raises `illegal` in the accepting cycle and causes no memory access and no register write.
- R9: Register 0 is ordinary storage: it can be written and read back like any other register.
- R10: While `busy` is high the instruction input is ignored: no memory access and no register write comes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is presented |
| instrWord | input | 32 | Instruction word |
| busy | output | 1 | Load data cycle in progress; input not accepted |
| illegal | output | 1 | Presented word matches no supported encoding |
| memAddr | output | 64 | Effective address |
| memWdata | output | 32 | Store data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memRdata | input | 32 | Read data, valid the cycle after `memRe` |

## Verification
Memory strobes, address, store data and `illegal` are combinational on the presented word, so the bench samples them in the accepting cycle, one time step after driving the word on the falling edge. Register writes land on the following rising edge; a load's write lands one edge later, after the `busy` cycle, and the bench samples `busy` at the falling edge between the two. Register contents are read back through a store-with-update with zero displacement, which puts the whole 64-bit register on `memAddr` and writes the same value back.

// File: rtl/wexec_pkg.sv
package wexec_pkg;
  localparam int XLEN  = 64;
  localparam int WLEN  = 32;
  localparam int IMMW  = 16;
  localparam int NREG  = 32;
  localparam int RIDXW = $clog2(NREG);
  localparam int OPW   = 6;
  localparam int XOW   = 10;

  localparam logic [OPW-1:0] OP_LDZ  = 6'b100000;
  localparam logic [OPW-1:0] OP_ST   = 6'b100100;
  localparam logic [OPW-1:0] OP_STU  = 6'b100101;
  localparam logic [OPW-1:0] OP_ADDI = 6'b001110;
  localparam logic [OPW-1:0] OP_EXT  = 6'b011111;
  localparam logic [XOW-1:0] XO_OR   = 10'b0110111100;

  typedef enum logic [1:0] {WB_SUM, WB_OR, WB_LOAD} wbSel_e;
  typedef enum logic [1:0] {IDX_RT, IDX_RA, IDX_PEND} wbIdx_e;

  typedef struct packed {
    logic   regWe;
    wbSel_e wbSel;
    wbIdx_e wbIdx;
    logic   baseZero;
    logic   memWe;
    logic   memRe;
  } strobe_t;
endpackage

// File: rtl/wexec_ctrl.sv
module wexec_ctrl
  import wexec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic [OPW-1:0]  opcode,
  input  logic [XOW-1:0]  extOp,
  input  logic [RIDXW-1:0] raField,
  output strobe_t         strb,
  output logic            busy,
  output logic            illegal
);
  logic waitQ;
  logic accept;

  assign accept = instrValid && !waitQ;
  assign busy   = waitQ;

  always_comb begin
    strb.regWe    = 1'b0;
    strb.wbSel    = WB_SUM;
    strb.wbIdx    = IDX_RT;
    strb.baseZero = 1'b0;
    strb.memWe    = 1'b0;
    strb.memRe    = 1'b0;
    illegal       = 1'b0;
    if (waitQ) begin
      strb.regWe = 1'b1;
      strb.wbSel = WB_LOAD;
      strb.wbIdx = IDX_PEND;
    end else if (accept) begin
      unique case (opcode)
        OP_LDZ: begin
          strb.memRe    = 1'b1;
          strb.baseZero = (raField == '0);
        end
        OP_ST: begin
          strb.memWe    = 1'b1;
          strb.baseZero = (raField == '0);
        end
        OP_STU: begin
          strb.memWe = 1'b1;
          strb.regWe = 1'b1;
          strb.wbIdx = IDX_RA;
        end
        OP_ADDI: begin
          strb.regWe    = 1'b1;
          strb.baseZero = (raField == '0);
        end
        OP_EXT: begin
          if (extOp == XO_OR) begin
            strb.regWe = 1'b1;
            strb.wbSel = WB_OR;
            strb.wbIdx = IDX_RA;
          end else begin
            illegal = 1'b1;
          end
        end
        default: illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) waitQ <= 1'b0;
    else       waitQ <= accept && (opcode == OP_LDZ);
  end

  assert_busy_after_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy && opcode == OP_LDZ) |=> busy);
  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!strb.memWe && !strb.memRe && !strb.regWe));
  assert_mem_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memWe && strb.memRe));
  assert_busy_no_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strb.memWe && !strb.memRe && !illegal));
endmodule

// File: rtl/wexec_dpath.sv
module wexec_dpath
  import wexec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [RIDXW-1:0] rtField,
  input  logic [RIDXW-1:0] raField,
  input  logic [RIDXW-1:0] rbField,
  input  logic [IMMW-1:0]  immField,
  input  strobe_t          strb,
  input  logic [WLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [WLEN-1:0]  memWdata
);
  logic [XLEN-1:0]  gpr [NREG];
  logic [XLEN-1:0]  baseVal, immExt, sumVal, wbData;
  logic [RIDXW-1:0] pendRt, wbIdx;

  assign baseVal  = strb.baseZero ? '0 : gpr[raField];
  assign immExt   = {{(XLEN-IMMW){immField[IMMW-1]}}, immField};
  assign sumVal   = baseVal + immExt;
  assign memAddr  = sumVal;
  assign memWdata = gpr[rtField][WLEN-1:0];

  always_comb begin
    unique case (strb.wbSel)
      WB_OR:   wbData = gpr[rtField] | gpr[rbField];
      WB_LOAD: wbData = {{(XLEN-WLEN){1'b0}}, memRdata};
      default: wbData = sumVal;
    endcase
    unique case (strb.wbIdx)
      IDX_RA:   wbIdx = raField;
      IDX_PEND: wbIdx = pendRt;
      default:  wbIdx = rtField;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
      pendRt <= '0;
    end else begin
      if (strb.regWe) gpr[wbIdx] <= wbData;
      if (strb.memRe) pendRt <= rtField;
    end
  end

  assert_load_wb_follows_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWe && strb.wbSel == WB_LOAD) |-> $past(strb.memRe));
  assert_load_no_early_wb_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRe |-> !strb.regWe);
endmodule

// File: rtl/word_exec_unit.sv
module word_exec_unit
  import wexec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  output logic        busy,
  output logic        illegal,
  output logic [63:0] memAddr,
  output logic [31:0] memWdata,
  output logic        memWe,
  output logic        memRe,
  input  logic [31:0] memRdata
);
  strobe_t strb;
  logic    unusedRecordFlag;

  assign unusedRecordFlag = instrWord[0];

  wexec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .opcode(instrWord[31:26]), .extOp(instrWord[10:1]), .raField(instrWord[20:16]),
    .strb(strb), .busy(busy), .illegal(illegal)
  );

  wexec_dpath u_dpath (
    .clk(clk), .rstN(rstN),
    .rtField(instrWord[25:21]), .raField(instrWord[20:16]),
    .rbField(instrWord[15:11]), .immField(instrWord[15:0]),
    .strb(strb), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memWe = strb.memWe;
  assign memRe = strb.memRe;
endmodule

// File: tb/word_exec_unit_bench.sv
module word_exec_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        busy, illegal, memWe, memRe;
  logic [63:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int fails  = 0;
  logic [63:0] sAddr;
  logic [31:0] sWdata;
  logic sWe, sRe, sIll, sBusy;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_exec_unit u_word_exec_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .busy(busy), .illegal(illegal), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .memRdata(memRdata)
  );

  function automatic logic [31:0] encD(input logic [5:0] op, input int rt, input int ra,
                                        input logic [15:0] d);
    return {op, 5'(rt), 5'(ra), d};
  endfunction

  function automatic logic [31:0] encOr(input int rs, input int ra, input int rb,
                                         input logic [9:0] xo, input logic rc);
    return {6'b011111, 5'(rs), 5'(ra), 5'(rb), xo, rc};
  endfunction

  function automatic logic [63:0] sx(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = w;
    #1;
    sAddr = memAddr; sWdata = memWdata; sWe = memWe; sRe = memRe;
    sIll = illegal; sBusy = busy;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  // nondestructive read: store-with-update, zero displacement, source = base
  task automatic readReg(input int r, output logic [63:0] v);
    issue(encD(6'b100101, r, r, 16'h0000));
    v = sAddr;
  endtask

  task automatic expectReg(input int r, input logic [63:0] exp, input string tag);
    logic [63:0] v;
    readReg(r, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy && !illegal && !memWe && !memRe, "R1 idle outputs",
        {busy, illegal, memWe, memRe}, 0);
    expectReg(0, 0, "R1 reg0 reset");
    expectReg(7, 0, "R1 reg7 reset");
    expectReg(31, 0, "R1 reg31 reset");
  endtask

  task automatic testAddi();
    issue(encD(6'b001110, 3, 0, 16'd100));
    expectReg(3, 64'd100, "R2 addi zero base");
    issue(encD(6'b001110, 4, 3, 16'd5));
    expectReg(4, 64'd105, "R2 addi reg base");
    issue(encD(6'b001110, 5, 0, 16'hFFFF));
    expectReg(5, '1, "R3 addi minus one");
    issue(encD(6'b001110, 6, 3, 16'h8000));
    expectReg(6, 64'd100 + sx(16'h8000), "R3 addi most negative");
  endtask

  task automatic testReg0();
    issue(encD(6'b001110, 0, 0, 16'h0077));
    expectReg(0, 64'h77, "R9 reg0 written");
    issue(encD(6'b001110, 8, 0, 16'd1));
    expectReg(8, 64'd1, "R2 base field 0 ignores reg0");
  endtask

  task automatic testStore();
    issue(encD(6'b001110, 9, 0, 16'hFFFE));
    issue(encD(6'b100100, 9, 4, 16'hFFFC));
    chk(sWe && !sRe, "R5 store strobes", {sWe, sRe}, 2'b10);
    chk(sAddr == 64'd101, "R5 store address", sAddr, 64'd101);
    chk(sWdata == 32'hFFFF_FFFE, "R5 store low word", sWdata, 32'hFFFF_FFFE);
    issue(encD(6'b100100, 9, 0, 16'h0010));
    chk(sAddr == 64'h10, "R5 store zero base", sAddr, 64'h10);
    expectReg(0, 64'h77, "R5 store leaves reg0");
    expectReg(9, sx(16'hFFFE), "R5 store leaves source");
  endtask

  task automatic testStoreUpdate();
    issue(encD(6'b100101, 4, 0, 16'd8));
    chk(sWe && sAddr == 64'h7F, "R6 update uses reg0 base", sAddr, 64'h7F);
    chk(sWdata == 32'd105, "R6 update store data", sWdata, 32'd105);
    expectReg(0, 64'h7F, "R6 reg0 updated");
    issue(encD(6'b100101, 4, 3, 16'hFF9C));
    chk(sAddr == 64'd0, "R6 negative displacement", sAddr, 0);
    expectReg(3, 64'd0, "R6 base updated");
  endtask

  task automatic testLoad();
    memRdata = 32'hDEAD_BEEF;
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = encD(6'b100000, 9, 4, 16'd3);
    #1;
    chk(memRe && !memWe && memAddr == 64'd108, "R4 load request", memAddr, 64'd108);
    @(negedge clk);
    // busy cycle: present an add that must be dropped
    instrWord = encD(6'b001110, 10, 0, 16'd55);
    #1;
    chk(busy, "R4 busy in data cycle", busy, 1);
    chk(!memWe && !memRe && !illegal, "R10 no access while busy",
        {memWe, memRe, illegal}, 0);
    @(negedge clk);
    instrValid = 1'b0;
    chk(!busy, "R4 busy lasts one cycle", busy, 0);
    memRdata = 32'h1234_5678;
    expectReg(9, 64'h0000_0000_DEAD_BEEF, "R4 load zero fill");
    expectReg(10, 64'd0, "R10 ignored add");
    issue(encD(6'b100000, 11, 0, 16'h0040));
    chk(sAddr == 64'h40, "R4 load zero base", sAddr, 64'h40);
    @(negedge clk);
    expectReg(11, 64'h1234_5678, "R4 second load");
  endtask

  task automatic testOr();
    issue(encD(6'b001110, 12, 0, 16'h0F0F));
    issue(encD(6'b001110, 14, 0, 16'h7000));
    issue(encOr(12, 13, 14, 10'b0110111100, 1'b1));
    expectReg(13, 64'h7F0F, "R7 or with record flag");
    issue(encOr(5, 15, 12, 10'b0110111100, 1'b0));
    expectReg(15, '1, "R7 or without record flag");
  endtask

  task automatic testIllegal();
    issue(encOr(12, 13, 12, 10'b0110111101, 1'b0));
    chk(sIll && !sWe && !sRe, "R8 wrong extended op", {sIll, sWe, sRe}, 3'b100);
    expectReg(13, 64'h7F0F, "R8 no write on wrong extended op");
    issue(32'hFFFF_FFFF);
    chk(sIll && !sWe && !sRe, "R8 all-ones word", {sIll, sWe, sRe}, 3'b100);
    expectReg(31, 64'd0, "R8 no write on all-ones word");
    issue(encD(6'b001110, 1, 0, 16'd1));
    chk(!sIll, "R8 legal word not flagged", sIll, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAddi();
    testReg0();
    testStore();
    testStoreUpdate();
    testLoad();
    testOr();
    testIllegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule